// File: doc/BRIEF.md
# Packed SIMD Immediate Shift Unit

This unit shifts every element of a 128-bit vector operand by an immediate amount, in one of three ways: shift left, arithmetic shift right or logical shift right. The operand is treated as sixteen 8-bit, eight 16-bit or four 32-bit elements. Each element is shifted on its own, so no bit crosses from one element into the next.

A single 6-bit immediate sets both the element width and the shift count. The element width is the largest power of two that is not above the immediate. The count is then taken from what is left of the immediate, and left and right shifts read it differently.

A pipeline upstream presents the source vector together with the instruction fields and a valid strobe. One cycle later the unit returns the shifted vector, a valid flag and an illegal-encoding flag. An illegal request leaves the result register as it was.

Top module: `simd_imm_shifter`

## Requirements
- R1: The element width is 8 for an immediate from 8 to 15, 16 for 16 to 31, and 32 for 32 to 63. The operand splits into 128/width elements. Element k occupies bits [k*width + width-1 : k*width].
- R2: For a left shift, the count is the immediate minus the element width, which gives 0 to width-1. Vacated low bits are filled with zeros and bits pushed out of the top are dropped.
- R3: For a right shift, the count is twice the element width minus the immediate, which gives 1 to width.
- R4: A left shift is selected when `opHi` (instruction bits [11:7]) equals 5'b01010 and `opBit4` is 1. A right shift is selected when `opHi` equals 5'b00000 and `opBit4` is 1.
- R5: A right shift with `unsignedSel` = 0 fills vacated bits with the element's sign bit. With `unsignedSel` = 1 it fills them with zeros. `unsignedSel` has no effect on left shifts.
- R6: Each element is shifted independently. Bits shifted out of one element never appear in a neighbouring element.
- R7: An accepted request with an immediate below 8 raises `outIllegal` and leaves `outVec` unchanged.
- R8: An accepted request whose `opHi`/`opBit4` pair matches neither shift form raises `outIllegal` and leaves `outVec` unchanged.
- R9: A right shift by the full element width, which happens when the immediate equals the width, gives zero for a logical shift and all copies of the sign bit for an arithmetic shift.
- R10: `outValid` is 1 exactly in the cycle after a cycle with `inValid` = 1. Without `inValid`, `outIllegal` is 0 and `outVec` holds its value.
- R11: While the synchronous reset `rst` is active, `outValid`, `outIllegal` and `outVec` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| opHi | input | 5 | Instruction bits [11:7] |
| opBit4 | input | 1 | Instruction bit 4 |
| unsignedSel | input | 1 | 1 selects logical right shift, 0 selects arithmetic |
| immField | input | 6 | Packed element width and shift count |
| srcVec | input | 128 | Source vector |
| outVec | output | 128 | Shifted vector, registered |
| outValid | output | 1 | Result valid |
| outIllegal | output | 1 | Request had an illegal encoding |

## Verification
The bench targets the ends of each immediate band. At 8, 16 and 32 a left shift moves nothing while a right shift clears or sign-fills the whole element; a design that wraps the count to zero would instead pass the element through untouched. Elements filled with ones and with alternating sign bits expose any leak across an element boundary, and they also expose a fill taken from the wrong bit, which would smear one element's sign into its neighbour. Immediates below 8 and stray opcode pairs must leave the previous result in place, and a design that loads anyway shows a changed vector. Random traffic covers the middle counts and every width.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int VEC_W     = 128;
  localparam int IMM_W     = 6;
  localparam int OPHI_W    = 5;
  localparam int NUM_SIZES = 3;
  localparam int CODE_W    = 2;
  localparam logic [OPHI_W-1:0] OPHI_LEFT  = 5'b01010;
  localparam logic [OPHI_W-1:0] OPHI_RIGHT = 5'b00000;

  typedef enum logic [1:0] {
    OP_LEFT  = 2'd0,
    OP_RIGHT = 2'd1,
    OP_NONE  = 2'd2
  } shOp_e;

  typedef struct packed {
    logic              load;
    logic              illegal;
    shOp_e             op;
    logic              logicalRight;
    logic [CODE_W-1:0] sizeCode;
    logic [IMM_W-1:0]  amount;
  } shStrobe_t;
endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
#(
  parameter int IMM_BITS = IMM_W,
  parameter int OP_BITS  = OPHI_W
) (
  input  logic                inValid,
  input  logic [OP_BITS-1:0]  opHi,
  input  logic                opBit4,
  input  logic                unsignedSel,
  input  logic [IMM_BITS-1:0] immField,
  output shStrobe_t           strobe
);
  localparam int WIDE = IMM_BITS + 1;

  logic [CODE_W-1:0] sizeCode;
  logic [WIDE-1:0]   sizeBits;
  logic [WIDE-1:0]   immWide;
  logic [WIDE-1:0]   leftAmt;
  logic [WIDE-1:0]   rightAmt;
  logic              immTooSmall;
  shOp_e             opSel;

  always_comb begin
    if (immField[5])      sizeCode = 2'd2;
    else if (immField[4]) sizeCode = 2'd1;
    else                  sizeCode = 2'd0;
  end

  assign immTooSmall = (immField[5:3] == 3'b000);
  assign sizeBits    = WIDE'(8) << sizeCode;
  assign immWide     = {1'b0, immField};
  assign leftAmt     = immWide - sizeBits;
  assign rightAmt    = (sizeBits << 1) - immWide;

  always_comb begin
    opSel = OP_NONE;
    if (opBit4 && opHi == OPHI_LEFT)       opSel = OP_LEFT;
    else if (opBit4 && opHi == OPHI_RIGHT) opSel = OP_RIGHT;
  end

  always_comb begin
    strobe.load         = inValid;
    strobe.illegal      = immTooSmall || (opSel == OP_NONE);
    strobe.op           = opSel;
    strobe.logicalRight = unsignedSel;
    strobe.sizeCode     = sizeCode;
    strobe.amount       = (opSel == OP_LEFT) ? leftAmt[IMM_BITS-1:0]
                                             : rightAmt[IMM_BITS-1:0];
  end
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter int DATA_W = VEC_W,
  parameter int SIZES  = NUM_SIZES
) (
  input  logic              clk,
  input  logic              rst,
  input  shStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcVec,
  output logic [DATA_W-1:0] outVec,
  output logic              outValid,
  output logic              outIllegal
);
  logic [DATA_W-1:0] sizeRes [SIZES];
  logic [DATA_W-1:0] shifted;
  logic              isLeft;

  assign isLeft = (strobe.op == OP_LEFT);

  for (genvar s = 0; s < SIZES; s++) begin : g_size
    localparam int LW    = 8 << s;
    localparam int LANES = DATA_W / LW;
    logic [DATA_W-1:0] res;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0]        laneIn;
      logic                 fill;
      logic signed [LW:0]   ext;
      logic signed [LW:0]   shr;
      logic [LW-1:0]        shl;
      assign laneIn = srcVec[l*LW +: LW];
      assign fill   = ~strobe.logicalRight & laneIn[LW-1];
      assign ext    = {fill, laneIn};
      assign shr    = ext >>> strobe.amount;
      assign shl    = laneIn << strobe.amount;
      assign res[l*LW +: LW] = isLeft ? shl : shr[LW-1:0];
    end
    assign sizeRes[s] = res;
  end

  always_comb begin
    shifted = sizeRes[0];
    for (int s = 1; s < SIZES; s++)
      if (int'(strobe.sizeCode) == s) shifted = sizeRes[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outVec     <= '0;
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= strobe.load;
      outIllegal <= strobe.load & strobe.illegal;
      if (strobe.load && !strobe.illegal) outVec <= shifted;
    end
  end
endmodule

// File: rtl/simd_imm_shifter.sv
module simd_imm_shifter
  import shf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OPHI_W-1:0] opHi,
  input  logic              opBit4,
  input  logic              unsignedSel,
  input  logic [IMM_W-1:0]  immField,
  input  logic [VEC_W-1:0]  srcVec,
  output logic [VEC_W-1:0]  outVec,
  output logic              outValid,
  output logic              outIllegal
);
  shStrobe_t strobe;

  shf_ctrl #(.IMM_BITS(IMM_W), .OP_BITS(OPHI_W)) u_ctrl (
    .inValid(inValid), .opHi(opHi), .opBit4(opBit4),
    .unsignedSel(unsignedSel), .immField(immField), .strobe(strobe)
  );

  shf_datapath #(.DATA_W(VEC_W), .SIZES(NUM_SIZES)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .srcVec(srcVec),
    .outVec(outVec), .outValid(outValid), .outIllegal(outIllegal)
  );
endmodule

// File: rtl/shf_chk.sv
module shf_chk
  import shf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [OPHI_W-1:0] opHi,
  input logic              opBit4,
  input logic              unsignedSel,
  input logic [IMM_W-1:0]  immField,
  input logic [VEC_W-1:0]  srcVec,
  input logic [VEC_W-1:0]  outVec,
  input logic              outValid,
  input logic              outIllegal
);
  logic badOp;
  assign badOp = !(opBit4 && (opHi == OPHI_LEFT || opHi == OPHI_RIGHT));

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outIllegal && $stable(outVec)));
  // R7
  small_imm_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && immField < 6'd8) |=> (outIllegal && $stable(outVec)));
  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && badOp) |=> (outIllegal && $stable(outVec)));
  // R2
  left_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && opBit4 && opHi == OPHI_LEFT && immField == 6'd8)
      |=> (outVec == $past(srcVec)));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && !outIllegal && outVec == '0));
endmodule

bind simd_imm_shifter shf_chk u_chk (.*);

// File: tb/test_simd_imm_shifter.sv
`timescale 1ns/1ps
module test_simd_imm_shifter;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [4:0]   opHi = '0;
  logic         opBit4 = 1'b0;
  logic         unsignedSel = 1'b0;
  logic [5:0]   immField = '0;
  logic [127:0] srcVec = '0;
  logic [127:0] outVec;
  logic         outValid;
  logic         outIllegal;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [127:0] expVec = '0;

  always #4 clk = ~clk;

  simd_imm_shifter i_simd_imm_shifter (
    .clk(clk), .rst(rst), .inValid(inValid), .opHi(opHi), .opBit4(opBit4),
    .unsignedSel(unsignedSel), .immField(immField), .srcVec(srcVec),
    .outVec(outVec), .outValid(outValid), .outIllegal(outIllegal)
  );

  function automatic logic [127:0] refShift(input logic left, input logic uns,
                                            input logic [5:0] imm,
                                            input logic [127:0] src);
    logic [127:0] res;
    int sz;
    int amt;
    res = '0;
    sz  = (imm >= 32) ? 32 : (imm >= 16) ? 16 : 8;
    amt = left ? int'(imm) - sz : 2 * sz - int'(imm);
    for (int i = 0; i < 128 / sz; i++) begin
      longint v;
      v = 0;
      for (int b = 0; b < sz; b++) v[b] = src[i*sz + b];
      if (left) v = v << amt;
      else begin
        if (!uns && v[sz-1]) v = v | (-64'sd1 <<< sz);
        v = v >>> amt;
      end
      for (int b = 0; b < sz; b++) res[i*sz + b] = v[b];
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [127:0] actV, input logic [127:0] expV,
                       input logic actVal, input logic expVal,
                       input logic actIll, input logic expIll);
    checks++;
    if (actV !== expV || actVal !== expVal || actIll !== expIll) begin
      fails++;
      $display("FAIL %s: vec=%h valid=%b illegal=%b expected vec=%h valid=%b illegal=%b",
               req, actV, actVal, actIll, expV, expVal, expIll);
    end
  endtask

  task automatic doOp(input string req, input logic [4:0] oh, input logic b4,
                      input logic uns, input logic [5:0] imm, input logic [127:0] src);
    logic legal;
    logic left;
    legal = (imm >= 8) && b4 && (oh == 5'b01010 || oh == 5'b00000);
    left  = (oh == 5'b01010);
    inValid = 1'b1; opHi = oh; opBit4 = b4; unsignedSel = uns;
    immField = imm; srcVec = src;
    if (legal) expVec = refShift(left, uns, imm, src);
    @(negedge clk);
    check(req, outVec, expVec, outValid, 1'b1, outIllegal, !legal);
  endtask

  task automatic idle(input string req);
    inValid = 1'b0;
    srcVec = ~srcVec;
    @(negedge clk);
    check(req, outVec, expVec, outValid, 1'b0, outIllegal, 1'b0);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd7331;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R11", outVec, 128'd0, outValid, 1'b0, outIllegal, 1'b0);
    rst = 1'b0;

    // R2: left by zero, then by 7 on all-ones bytes
    doOp("R2", 5'b01010, 1'b1, 1'b0, 6'd8, 128'h0123456789abcdef_fedcba9876543210);
    doOp("R2", 5'b01010, 1'b1, 1'b1, 6'd15, {16{8'hff}});
    // R6: left shift must not leak into neighbour lanes
    doOp("R6", 5'b01010, 1'b1, 1'b0, 6'd20, {8{16'hf00f}});
    // R1 and R3: 32-bit lane, count 1
    doOp("R3", 5'b00000, 1'b1, 1'b1, 6'd63, {4{32'h8000_0001}});
    // R5: arithmetic vs logical on alternating signs
    doOp("R5", 5'b00000, 1'b1, 1'b0, 6'd12, {8{8'h80, 8'h7f}});
    doOp("R5", 5'b00000, 1'b1, 1'b1, 6'd12, {8{8'h80, 8'h7f}});
    // R9: full-width right shifts
    doOp("R9", 5'b00000, 1'b1, 1'b0, 6'd8, {8{8'h81, 8'h7e}});
    doOp("R9", 5'b00000, 1'b1, 1'b1, 6'd16, {8{16'h8001}});
    doOp("R9", 5'b00000, 1'b1, 1'b0, 6'd32, {2{32'h8000_0000, 32'h7fff_ffff}});
    // R7: immediate below 8
    doOp("R7", 5'b01010, 1'b1, 1'b0, 6'd5, {16{8'h5a}});
    // R8: bad opcode, then bit4 clear
    doOp("R8", 5'b00110, 1'b1, 1'b0, 6'd20, {16{8'h33}});
    doOp("R8", 5'b01010, 1'b0, 1'b0, 6'd20, {16{8'h33}});
    // R10: idle holds
    idle("R10");
    idle("R10");
    // R4: back-to-back left then right on the same data
    doOp("R4", 5'b01010, 1'b1, 1'b0, 6'd33, {4{32'hc000_0003}});
    doOp("R4", 5'b00000, 1'b1, 1'b0, 6'd33, {4{32'hc000_0003}});

    for (int n = 0; n < 400; n++) begin
      int kind;
      logic [5:0] imm;
      logic [127:0] src;
      kind = int'($urandom_range(9, 0));
      imm  = 6'($urandom_range(63, 0));
      src  = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (kind < 4)      doOp("R1", 5'b01010, 1'b1, 1'($urandom()), imm, src);
      else if (kind < 8) doOp("R3", 5'b00000, 1'b1, 1'($urandom()), imm, src);
      else if (kind == 8) doOp("R8", 5'($urandom()), 1'($urandom()), 1'b0, imm, src);
      else idle("R10");
    end

    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    expVec = '0;
    check("R11", outVec, 128'd0, outValid, 1'b0, outIllegal, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule